// File: doc/BRIEF.md
# Register Page Selector for Two Command Ports

This block keeps track of which of three register pages is open: the default page, the extended page (conversion results and general-purpose I/O), or the nonvolatile-memory page (stored configuration and fault data). Two serial front ends feed it, one with an I2C-style command set and one with a JTAG-style command set. Each front end delivers an 8-bit command byte together with a one-cycle valid strobe. The 2-bit page select output tells the downstream register access logic which page a read or a write reaches.

Each command set has its own codes for four switches: open the extended page, leave the extended page, open the nonvolatile page, and leave the nonvolatile page. Both leave commands return to the default page from any page. The block consumes page commands. Every other command byte is forwarded one cycle later, marked with the port it came from. The two front ends must not be used at once. If both strobe in the same cycle, both commands are dropped and a one-cycle conflict pulse is raised.

Top module: `page_sel`

## Requirements
- R1: After reset, page is 2'b00 (default), conflict is 0 and fwd_vld is 0. page never holds 2'b11.
- R2: A lone I2C command 8'h98 sets page to 2'b01 (extended) and a lone I2C command 8'h9A sets page to 2'b10 (nonvolatile), both on the following clock edge and from any page.
- R3: A lone I2C command 8'h99 or 8'h9B sets page to 2'b00 on the following edge, whichever page is open.
- R4: A lone JTAG command 8'h09 sets page to 2'b01 and 8'h0B sets page to 2'b10. 8'h0A or 8'h0C sets page to 2'b00 from any page.
- R5: A code that belongs only to the other port's command set is not a page command on this port: it leaves page unchanged and is forwarded.
- R6: When i2c_vld and jtag_vld are both high in one cycle, page is unchanged, nothing is forwarded, and conflict is high for exactly the next cycle.
- R7: A lone command that is not a page command appears on fwd_cmd one cycle later, with fwd_vld high and fwd_src set to 0 for I2C or 1 for JTAG. A page command gives fwd_vld low.
- R8: In a cycle with no valid strobe, page holds, and in the next cycle fwd_vld and conflict are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2c_vld | input | 1 | Command strobe from the I2C-side front end |
| i2c_cmd | input | 8 | Command byte from the I2C-side front end |
| jtag_vld | input | 1 | Command strobe from the JTAG-side front end |
| jtag_cmd | input | 8 | Command byte from the JTAG-side front end |
| page | output | 2 | Open page: 00 default, 01 extended, 10 nonvolatile |
| conflict | output | 1 | One-cycle pulse after a same-cycle command clash |
| fwd_vld | output | 1 | Forwarded non-page command is valid |
| fwd_cmd | output | 8 | Forwarded command byte |
| fwd_src | output | 1 | Source of the forwarded byte: 0 I2C, 1 JTAG |

## Verification
The bench builds the block with its default parameters: an 8-bit command width and the eight page codes listed in the requirements. With these values the bench can reach every transition between the three pages from both ports. It can also send each port the other port's codes to check that they are forwarded and do not switch pages. A mixed random phase sends clashes, leave commands issued while the other non-default page is open, and idle cycles. A behavioural model compares all outputs on every clock.

// File: rtl/page_sel.sv
module page_sel #(
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] I2C_EXT_ON   = 8'h98,
  parameter logic [CMD_W-1:0] I2C_EXT_OFF  = 8'h99,
  parameter logic [CMD_W-1:0] I2C_EE_ON    = 8'h9A,
  parameter logic [CMD_W-1:0] I2C_EE_OFF   = 8'h9B,
  parameter logic [CMD_W-1:0] JTAG_EXT_ON  = 8'h09,
  parameter logic [CMD_W-1:0] JTAG_EXT_OFF = 8'h0A,
  parameter logic [CMD_W-1:0] JTAG_EE_ON   = 8'h0B,
  parameter logic [CMD_W-1:0] JTAG_EE_OFF  = 8'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i2c_vld,
  input  logic [CMD_W-1:0] i2c_cmd,
  input  logic             jtag_vld,
  input  logic [CMD_W-1:0] jtag_cmd,
  output logic [1:0]       page,
  output logic             conflict,
  output logic             fwd_vld,
  output logic [CMD_W-1:0] fwd_cmd,
  output logic             fwd_src
);
  localparam logic [1:0] PG_DEF = 2'b00;
  localparam logic [1:0] PG_EXT = 2'b01;
  localparam logic [1:0] PG_EE  = 2'b10;

  logic solo_i2c, solo_jtag, clash;
  logic go_ext, go_ee, go_def, hit;
  logic [CMD_W-1:0] cmd;

  assign solo_i2c  = i2c_vld & ~jtag_vld;
  assign solo_jtag = jtag_vld & ~i2c_vld;
  assign clash     = i2c_vld & jtag_vld;
  assign cmd       = solo_jtag ? jtag_cmd : i2c_cmd;

  assign go_ext = (solo_i2c  && i2c_cmd  == I2C_EXT_ON) ||
                  (solo_jtag && jtag_cmd == JTAG_EXT_ON);
  assign go_ee  = (solo_i2c  && i2c_cmd  == I2C_EE_ON) ||
                  (solo_jtag && jtag_cmd == JTAG_EE_ON);
  assign go_def = (solo_i2c  && (i2c_cmd  == I2C_EXT_OFF  || i2c_cmd  == I2C_EE_OFF)) ||
                  (solo_jtag && (jtag_cmd == JTAG_EXT_OFF || jtag_cmd == JTAG_EE_OFF));
  assign hit    = go_ext | go_ee | go_def;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page     <= PG_DEF;
      conflict <= 1'b0;
      fwd_vld  <= 1'b0;
      fwd_cmd  <= '0;
      fwd_src  <= 1'b0;
    end else begin
      conflict <= clash;
      fwd_vld  <= (solo_i2c | solo_jtag) & ~hit;
      if ((solo_i2c | solo_jtag) & ~hit) begin
        fwd_cmd <= cmd;
        fwd_src <= solo_jtag;
      end
      if (go_ext)      page <= PG_EXT;
      else if (go_ee)  page <= PG_EE;
      else if (go_def) page <= PG_DEF;
    end
  end
endmodule

// File: rtl/page_sel_chk.sv
module page_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       i2c_vld,
  input logic [7:0] i2c_cmd,
  input logic       jtag_vld,
  input logic [7:0] jtag_cmd,
  input logic [1:0] page,
  input logic       conflict,
  input logic       fwd_vld,
  input logic [7:0] fwd_cmd,
  input logic       fwd_src
);
  logic i_page, j_page;
  assign i_page = i2c_cmd == 8'h98 || i2c_cmd == 8'h99 || i2c_cmd == 8'h9A || i2c_cmd == 8'h9B;
  assign j_page = jtag_cmd == 8'h09 || jtag_cmd == 8'h0A || jtag_cmd == 8'h0B || jtag_cmd == 8'h0C;

  p_legal_page_r1: assert property (@(posedge clk) disable iff (!rst_n) page != 2'b11);
  p_i2c_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_vld && !jtag_vld && i2c_cmd == 8'h98) |=> page == 2'b01);
  p_i2c_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_vld && !jtag_vld && (i2c_cmd == 8'h99 || i2c_cmd == 8'h9B)) |=> page == 2'b00);
  p_jtag_ee_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (jtag_vld && !i2c_vld && jtag_cmd == 8'h0B) |=> page == 2'b10);
  p_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_vld && jtag_vld) |=> conflict && !fwd_vld && $stable(page));
  p_fwd_i2c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_vld && !jtag_vld && !i_page) |=> fwd_vld && !fwd_src && fwd_cmd == $past(i2c_cmd));
  p_fwd_jtag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (jtag_vld && !i2c_vld && !j_page) |=> fwd_vld && fwd_src && $stable(page));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!i2c_vld && !jtag_vld) |=> !fwd_vld && !conflict && $stable(page));
endmodule

bind page_sel page_sel_chk u_chk (.*);

// File: tb/tb_page_sel.sv
module tb_page_sel;
  logic clk = 0, rst_n = 0;
  logic i2c_vld = 0, jtag_vld = 0;
  logic [7:0] i2c_cmd = 0, jtag_cmd = 0;
  logic [1:0] page;
  logic conflict, fwd_vld, fwd_src;
  logic [7:0] fwd_cmd;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int m_page = 0, m_conf = 0, m_fv = 0, m_fc = 0, m_fs = 0;

  always #10 clk = ~clk;

  page_sel dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d, expected end before 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int dec(bit jt, int c);
    if (!jt) begin
      if (c == 'h98) return 1;
      if (c == 'h9A) return 2;
      if (c == 'h99 || c == 'h9B) return 0;
    end else begin
      if (c == 'h09) return 1;
      if (c == 'h0B) return 2;
      if (c == 'h0A || c == 'h0C) return 0;
    end
    return -1;
  endfunction

  task automatic cmp(string tag);
    bit bad;
    checks++;
    bad = (page != m_page[1:0]) || (conflict != m_conf[0]) || (fwd_vld != m_fv[0]) ||
          (m_fv != 0 && (fwd_cmd != m_fc[7:0] || fwd_src != m_fs[0]));
    if (bad) begin
      errors++;
      $display("FAIL %s: actual page=%0d conf=%0d fv=%0d fc=%h fs=%0d, expected page=%0d conf=%0d fv=%0d fc=%h fs=%0d",
               tag, page, conflict, fwd_vld, fwd_cmd, fwd_src, m_page, m_conf, m_fv, m_fc, m_fs);
    end
  endtask

  task automatic step(bit iv, int ic, bit jv, int jc, string tag);
    int d;
    i2c_vld = iv; i2c_cmd = ic[7:0]; jtag_vld = jv; jtag_cmd = jc[7:0];
    @(posedge clk);
    m_conf = (iv && jv) ? 1 : 0;
    m_fv = 0;
    if (iv != jv) begin
      d = dec(jv, jv ? jc : ic);
      if (d >= 0) m_page = d;
      else begin m_fv = 1; m_fc = jv ? jc : ic; m_fs = jv ? 1 : 0; end
    end
    @(negedge clk);
    i2c_vld = 0; jtag_vld = 0;
    cmp(tag);
  endtask

  int codes[10] = '{'h98, 'h99, 'h9A, 'h9B, 'h09, 'h0A, 'h0B, 'h0C, 'h00, 'h55};

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset");
    rst_n = 1;
    @(negedge clk);
    cmp("R1 after release");
    step(1, 'h98, 0, 0, "R2 i2c ext");
    step(1, 'h9A, 0, 0, "R2 i2c ee from ext");
    step(1, 'h99, 0, 0, "R3 i2c ext-off while on ee");
    step(1, 'h98, 0, 0, "R2 i2c ext again");
    step(1, 'h9B, 0, 0, "R3 i2c ee-off while on ext");
    step(0, 0, 1, 'h0B, "R4 jtag ee");
    step(0, 0, 1, 'h0A, "R4 jtag ext-off while on ee");
    step(0, 0, 1, 'h09, "R4 jtag ext");
    step(0, 0, 1, 'h0C, "R4 jtag ee-off while on ext");
    step(1, 'h09, 0, 0, "R5 jtag code on i2c");
    step(0, 0, 1, 'h98, "R5 i2c code on jtag");
    step(1, 'h98, 1, 'h0B, "R6 clash");
    step(0, 0, 0, 0, "R6 pulse ends");
    step(1, 'h3C, 0, 0, "R7 i2c forward");
    step(0, 0, 1, 'hE1, "R7 jtag forward");
    step(0, 0, 0, 0, "R8 idle");
    for (int k = 0; k < 400; k++) begin
      bit iv, jv;
      int ic, jc, r;
      r = $urandom_range(0, 9);
      iv = (r < 5); jv = (r > 3 && r < 8);
      ic = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : codes[$urandom_range(0, 9)];
      jc = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : codes[$urandom_range(0, 9)];
      step(iv, ic, jv, jc, "R7 random mix");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule